// File: doc/BRIEF.md
# Reorder Queue with Precise Fault Recovery

This block is the in-order result queue of an out-of-order core. Instructions take a slot at the tail when dispatched, and the slot index becomes the rename tag that consumers wait on. Execution units report results, fault flags and branch outcomes back by tag, in any order. Results leave from the head, one per cycle and strictly in program order, as writes to the architectural register file. A fault or a mispredicted branch takes effect only when its instruction reaches the head. At that point the whole queue is cleared and fetch is steered to the handler or to the corrected target.

A source-operand lookup port serves the rename stage. It searches the live slots from youngest to oldest for the requested register. On a match it returns the value if that slot has completed, or the slot tag if it has not. When no slot matches, it returns the architectural register file value supplied on `arf_value`.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_tag` is 0, and both `cm_valid` and `flush_valid` are 0.
- R2: Each accepted dispatch receives the current tail index on `disp_tag`. Consecutive dispatches get consecutive indices modulo DEPTH, so with DEPTH=8 a tail at 5 yields 5,6,7,0,1,...
- R3: With DEPTH live slots, `disp_ready` is 0 and a dispatch request is ignored. No slot is created, and nothing extra ever commits from it.
- R4: Writebacks may arrive in any order. No commit is presented while the oldest live slot has not completed.
- R5: When the oldest slot has completed without a fault, `cm_valid` is 1 with that slot's destination and value. At most one slot retires per cycle, and retirement follows dispatch order.
- R6: When the oldest completed slot is marked faulting, `flush_valid` and `flush_fault` are 1, `flush_pc` equals HANDLER_PC and `flush_epc` equals that slot's PC. No register write is presented, and one cycle later every slot is gone and the tail is back at 0.
- R7: When the oldest completed slot is a mispredicted branch, its result is committed in the same cycle that `flush_valid` is 1 with `flush_fault`=0 and `flush_pc` equal to its reported target. All younger slots are discarded without committing.
- R8: A lookup that matches live slots picks the youngest match. It returns `look_ready`=1 with that slot's value if the slot has completed, otherwise `look_ready`=0 with the slot index on `look_tag`. `look_hit` is 1 in both cases.
- R9: A lookup that matches no live slot returns `look_hit`=0, `look_ready`=1 and `look_value` equal to `arf_value`.
- R10: A flush wins over a dispatch in the same cycle: that dispatch creates no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_dst | input | RW | Destination register of the dispatched instruction |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_tag | output | IDX_W | Slot index assigned to the dispatch |
| wb_valid | input | 1 | Writeback strobe |
| wb_tag | input | IDX_W | Slot being completed |
| wb_value | input | XLEN | Result value |
| wb_fault | input | 1 | Instruction raised a fault |
| wb_mispredict | input | 1 | Branch was mispredicted |
| wb_target | input | PC_W | Corrected branch target |
| look_reg | input | RW | Source register being looked up |
| arf_value | input | XLEN | Architectural value of look_reg |
| look_hit | output | 1 | A live slot names look_reg |
| look_ready | output | 1 | Operand value is available |
| look_value | output | XLEN | Operand value when ready |
| look_tag | output | IDX_W | Producing slot when not ready |
| cm_valid | output | 1 | Register file write this cycle |
| cm_dst | output | RW | Register written |
| cm_value | output | XLEN | Value written |
| flush_valid | output | 1 | Queue is cleared and fetch redirected |
| flush_fault | output | 1 | The flush is caused by a fault |
| flush_pc | output | PC_W | Fetch restart address |
| flush_epc | output | PC_W | PC of the instruction at the head |

## Verification
The hardest case to bring about is the one where the queue holds completed younger results that must never retire. This happens when the head is a faulting instruction or a mispredicted branch, and it requires every younger slot to be written back before the head itself. The stimulus therefore completes the younger slots first and the head last. It then shows that the discarded results never reach the commit port, and that the lookup falls back to the architectural value for their registers. The full-queue case is reached with the tail starting mid-ring, so the eight tags wrap past the end. A refused dispatch request is held while the queue is full.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Slot index that follows p in a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p + 1) % depth;
  endfunction

  // Slot that lies a steps younger than the head.
  function automatic int unsigned ring_slot(input int unsigned head, input int unsigned a,
                                            input int unsigned depth);
    return (head + a) % depth;
  endfunction

endpackage

// File: rtl/rq_ptr_ctrl.sv
module rq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  input  logic             retire,
  input  logic             flush,
  output logic             alloc_fire,
  output logic             full,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count
);
  import rq_pkg::*;

  assign full       = (count == CNT_W'(DEPTH));
  assign alloc_fire = alloc_req && !full && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (alloc_fire) tail <= IDX_W'(ring_next(int'(tail), DEPTH));
      if (retire)     head <= IDX_W'(ring_next(int'(head), DEPTH));
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire);
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (tail == IDX_W'(ring_next(int'($past(tail)), DEPTH))));

  // R3
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !retire && !flush) |=> $stable(tail));

  // R10
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && tail == '0 && head == '0));

endmodule

// File: rtl/rq_entry_store.sv
module rq_entry_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int RW    = 5,
  parameter int XLEN  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       alloc_fire,
  input  logic [IDX_W-1:0]           tail,
  input  logic [PC_W-1:0]            alloc_pc,
  input  logic [RW-1:0]              alloc_dst,
  input  logic                       retire,
  input  logic [IDX_W-1:0]           head,
  input  logic                       wb_valid,
  input  logic [IDX_W-1:0]           wb_tag,
  input  logic [XLEN-1:0]            wb_value,
  input  logic                       wb_fault,
  input  logic                       wb_mispredict,
  input  logic [PC_W-1:0]            wb_target,
  output logic [DEPTH-1:0]           ent_valid,
  output logic [DEPTH-1:0]           ent_done,
  output logic [DEPTH-1:0]           ent_fault,
  output logic [DEPTH-1:0]           ent_misp,
  output logic [DEPTH-1:0][PC_W-1:0] ent_pc,
  output logic [DEPTH-1:0][RW-1:0]   ent_dst,
  output logic [DEPTH-1:0][XLEN-1:0] ent_value,
  output logic [DEPTH-1:0][PC_W-1:0] ent_target
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic            r_valid, r_done, r_fault, r_misp;
    logic [PC_W-1:0] r_pc, r_target;
    logic [RW-1:0]   r_dst;
    logic [XLEN-1:0] r_value;
    logic            take_alloc, take_wb, take_ret;

    assign take_alloc = alloc_fire && (tail == IDX_W'(e));
    assign take_wb    = wb_valid && (wb_tag == IDX_W'(e)) && r_valid;
    assign take_ret   = retire && (head == IDX_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_valid  <= 1'b0;
        r_done   <= 1'b0;
        r_fault  <= 1'b0;
        r_misp   <= 1'b0;
        r_pc     <= '0;
        r_dst    <= '0;
        r_value  <= '0;
        r_target <= '0;
      end else if (flush) begin
        r_valid <= 1'b0;
        r_done  <= 1'b0;
        r_fault <= 1'b0;
        r_misp  <= 1'b0;
      end else if (take_alloc) begin
        r_valid <= 1'b1;
        r_done  <= 1'b0;
        r_fault <= 1'b0;
        r_misp  <= 1'b0;
        r_pc    <= alloc_pc;
        r_dst   <= alloc_dst;
      end else begin
        if (take_ret) r_valid <= 1'b0;
        if (take_wb) begin
          r_done   <= 1'b1;
          r_fault  <= wb_fault;
          r_misp   <= wb_mispredict;
          r_value  <= wb_value;
          r_target <= wb_target;
        end
      end
    end

    assign ent_valid[e]  = r_valid;
    assign ent_done[e]   = r_done;
    assign ent_fault[e]  = r_fault;
    assign ent_misp[e]   = r_misp;
    assign ent_pc[e]     = r_pc;
    assign ent_dst[e]    = r_dst;
    assign ent_value[e]  = r_value;
    assign ent_target[e] = r_target;
  end

endmodule

// File: rtl/rq_operand_search.sv
module rq_operand_search #(
  parameter int DEPTH = 8,
  parameter int RW    = 5,
  parameter int XLEN  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]           ent_valid,
  input  logic [DEPTH-1:0]           ent_done,
  input  logic [DEPTH-1:0][RW-1:0]   ent_dst,
  input  logic [DEPTH-1:0][XLEN-1:0] ent_value,
  input  logic [IDX_W-1:0]           head,
  input  logic [RW-1:0]              look_reg,
  input  logic [XLEN-1:0]            arf_value,
  output logic                       look_hit,
  output logic                       look_ready,
  output logic [XLEN-1:0]            look_value,
  output logic [IDX_W-1:0]           look_tag
);
  import rq_pkg::*;

  logic             found;
  logic [IDX_W-1:0] pick;
  logic [IDX_W-1:0] scan;

  // Walk from oldest to youngest; the last match standing is the youngest.
  always_comb begin
    found = 1'b0;
    pick  = '0;
    scan  = '0;
    for (int a = 0; a < DEPTH; a++) begin
      scan = IDX_W'(ring_slot(int'(head), a, DEPTH));
      if (ent_valid[scan] && ent_dst[scan] == look_reg) begin
        found = 1'b1;
        pick  = scan;
      end
    end
  end

  always_comb begin
    look_hit = found;
    if (!found) begin
      look_ready = 1'b1;
      look_value = arf_value;
      look_tag   = '0;
    end else if (ent_done[pick]) begin
      look_ready = 1'b1;
      look_value = ent_value[pick];
      look_tag   = pick;
    end else begin
      look_ready = 1'b0;
      look_value = '0;
      look_tag   = pick;
    end
  end

endmodule

// File: rtl/rq_retire_unit.sv
module rq_retire_unit #(
  parameter int PC_W = 32,
  parameter int RW   = 5,
  parameter int XLEN = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0800
) (
  input  logic            head_valid,
  input  logic            head_done,
  input  logic            head_fault,
  input  logic            head_misp,
  input  logic [PC_W-1:0] head_pc,
  input  logic [PC_W-1:0] head_target,
  input  logic [RW-1:0]   head_dst,
  input  logic [XLEN-1:0] head_value,
  output logic            cm_valid,
  output logic [RW-1:0]   cm_dst,
  output logic [XLEN-1:0] cm_value,
  output logic            retire,
  output logic            flush,
  output logic            flush_fault,
  output logic [PC_W-1:0] flush_pc,
  output logic [PC_W-1:0] flush_epc
);
  logic head_ready;

  assign head_ready  = head_valid && head_done;
  assign cm_valid    = head_ready && !head_fault;
  assign cm_dst      = head_dst;
  assign cm_value    = head_value;
  assign retire      = cm_valid;
  assign flush       = head_ready && (head_fault || head_misp);
  assign flush_fault = head_ready && head_fault;
  assign flush_pc    = head_fault ? HANDLER_PC : head_target;
  assign flush_epc   = head_pc;

endmodule

// File: rtl/reorder_queue.sv
module reorder_queue #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 32,
  parameter int RW    = 5,
  parameter int XLEN  = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0800,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_valid,
  input  logic [PC_W-1:0]  disp_pc,
  input  logic [RW-1:0]    disp_dst,
  output logic             disp_ready,
  output logic [IDX_W-1:0] disp_tag,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  input  logic             wb_fault,
  input  logic             wb_mispredict,
  input  logic [PC_W-1:0]  wb_target,
  input  logic [RW-1:0]    look_reg,
  input  logic [XLEN-1:0]  arf_value,
  output logic             look_hit,
  output logic             look_ready,
  output logic [XLEN-1:0]  look_value,
  output logic [IDX_W-1:0] look_tag,
  output logic             cm_valid,
  output logic [RW-1:0]    cm_dst,
  output logic [XLEN-1:0]  cm_value,
  output logic             flush_valid,
  output logic             flush_fault,
  output logic [PC_W-1:0]  flush_pc,
  output logic [PC_W-1:0]  flush_epc
);
  import rq_pkg::*;

  logic                       alloc_fire, full, retire, flush;
  logic [IDX_W-1:0]           head_q, tail_q;
  logic [CNT_W-1:0]           count_q;
  logic [DEPTH-1:0]           ent_valid, ent_done, ent_fault, ent_misp;
  logic [DEPTH-1:0][PC_W-1:0] ent_pc, ent_target;
  logic [DEPTH-1:0][RW-1:0]   ent_dst;
  logic [DEPTH-1:0][XLEN-1:0] ent_value;

  rq_ptr_ctrl #(.DEPTH(DEPTH)) ptr_i (
    .clk(clk), .rst_n(rst_n), .alloc_req(disp_valid), .retire(retire), .flush(flush),
    .alloc_fire(alloc_fire), .full(full), .head(head_q), .tail(tail_q), .count(count_q)
  );

  rq_entry_store #(.DEPTH(DEPTH), .PC_W(PC_W), .RW(RW), .XLEN(XLEN)) store_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_fire(alloc_fire), .tail(tail_q), .alloc_pc(disp_pc), .alloc_dst(disp_dst),
    .retire(retire), .head(head_q),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
    .wb_mispredict(wb_mispredict), .wb_target(wb_target),
    .ent_valid(ent_valid), .ent_done(ent_done), .ent_fault(ent_fault), .ent_misp(ent_misp),
    .ent_pc(ent_pc), .ent_dst(ent_dst), .ent_value(ent_value), .ent_target(ent_target)
  );

  rq_operand_search #(.DEPTH(DEPTH), .RW(RW), .XLEN(XLEN)) search_i (
    .ent_valid(ent_valid), .ent_done(ent_done), .ent_dst(ent_dst), .ent_value(ent_value),
    .head(head_q), .look_reg(look_reg), .arf_value(arf_value),
    .look_hit(look_hit), .look_ready(look_ready), .look_value(look_value), .look_tag(look_tag)
  );

  rq_retire_unit #(.PC_W(PC_W), .RW(RW), .XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) retire_i (
    .head_valid(ent_valid[head_q]), .head_done(ent_done[head_q]),
    .head_fault(ent_fault[head_q]), .head_misp(ent_misp[head_q]),
    .head_pc(ent_pc[head_q]), .head_target(ent_target[head_q]),
    .head_dst(ent_dst[head_q]), .head_value(ent_value[head_q]),
    .cm_valid(cm_valid), .cm_dst(cm_dst), .cm_value(cm_value), .retire(retire),
    .flush(flush), .flush_fault(flush_fault), .flush_pc(flush_pc), .flush_epc(flush_epc)
  );

  assign disp_ready  = !full;
  assign disp_tag    = tail_q;
  assign flush_valid = flush;

  // R5
  commit_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !flush_valid) |=> (head_q == IDX_W'(ring_next(int'($past(head_q)), DEPTH))));

  // R6
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fault |-> (!cm_valid && flush_valid));

endmodule

// File: tb/reorder_queue_tb.sv
module reorder_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int PC_W  = 32;
  localparam int RW    = 5;
  localparam int XLEN  = 32;
  localparam int IDX_W = 3;
  localparam logic [31:0] HANDLER = 32'h0000_0800;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             disp_valid = 1'b0;
  logic [PC_W-1:0]  disp_pc = '0;
  logic [RW-1:0]    disp_dst = '0;
  logic             disp_ready;
  logic [IDX_W-1:0] disp_tag;
  logic             wb_valid = 1'b0;
  logic [IDX_W-1:0] wb_tag = '0;
  logic [XLEN-1:0]  wb_value = '0;
  logic             wb_fault = 1'b0;
  logic             wb_mispredict = 1'b0;
  logic [PC_W-1:0]  wb_target = '0;
  logic [RW-1:0]    look_reg = '0;
  logic [XLEN-1:0]  arf_value = '0;
  logic             look_hit, look_ready;
  logic [XLEN-1:0]  look_value;
  logic [IDX_W-1:0] look_tag;
  logic             cm_valid;
  logic [RW-1:0]    cm_dst;
  logic [XLEN-1:0]  cm_value;
  logic             flush_valid, flush_fault;
  logic [PC_W-1:0]  flush_pc, flush_epc;

  int checks = 0;
  int failures = 0;
  int ncm = 0;
  logic [RW-1:0]   log_dst [64];
  logic [XLEN-1:0] log_val [64];

  always #4 clk = ~clk;

  reorder_queue #(.DEPTH(DEPTH), .PC_W(PC_W), .RW(RW), .XLEN(XLEN), .HANDLER_PC(HANDLER)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_pc(disp_pc), .disp_dst(disp_dst),
    .disp_ready(disp_ready), .disp_tag(disp_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .wb_value(wb_value), .wb_fault(wb_fault), .wb_mispredict(wb_mispredict), .wb_target(wb_target),
    .look_reg(look_reg), .arf_value(arf_value), .look_hit(look_hit), .look_ready(look_ready),
    .look_value(look_value), .look_tag(look_tag), .cm_valid(cm_valid), .cm_dst(cm_dst),
    .cm_value(cm_value), .flush_valid(flush_valid), .flush_fault(flush_fault),
    .flush_pc(flush_pc), .flush_epc(flush_epc)
  );

  // Each cycle with a commit presented retires exactly one slot at the next edge.
  always @(negedge clk) begin
    #2;
    if (rst_n && cm_valid && ncm < 64) begin
      log_dst[ncm] = cm_dst;
      log_val[ncm] = cm_value;
      ncm++;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dispatch(input logic [RW-1:0] dst, input logic [PC_W-1:0] pc,
                          input int exp_tag);
    disp_valid = 1'b1; disp_dst = dst; disp_pc = pc;
    #1;
    chk("R2 disp_tag", 64'(disp_tag), 64'(exp_tag));
    step();
    disp_valid = 1'b0;
  endtask

  task automatic writeback(input int tag, input logic [XLEN-1:0] val, input logic flt,
                           input logic mis, input logic [PC_W-1:0] tgt);
    wb_valid = 1'b1; wb_tag = IDX_W'(tag); wb_value = val;
    wb_fault = flt; wb_mispredict = mis; wb_target = tgt;
    step();
    wb_valid = 1'b0; wb_fault = 1'b0; wb_mispredict = 1'b0;
  endtask

  task automatic lookup(input string what, input logic [RW-1:0] r, input logic [XLEN-1:0] arf,
                        input logic hit, input logic rdy, input logic [XLEN-1:0] val,
                        input int tag);
    look_reg = r; arf_value = arf;
    #1;
    chk({what, " look_hit"}, 64'(look_hit), 64'(hit));
    chk({what, " look_ready"}, 64'(look_ready), 64'(rdy));
    if (rdy) chk({what, " look_value"}, 64'(look_value), 64'(val));
    if (hit && !rdy) chk({what, " look_tag"}, 64'(look_tag), 64'(tag));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 disp_ready", 64'(disp_ready), 64'd1);
    chk("R1 disp_tag", 64'(disp_tag), 64'd0);
    chk("R1 cm_valid", 64'(cm_valid), 64'd0);
    chk("R1 flush_valid", 64'(flush_valid), 64'd0);
    @(negedge clk);

    // R4 R5: five slots, completed youngest first
    for (int i = 0; i < 5; i++) dispatch(RW'(i + 1), 32'h100 + 32'(4 * i), i);
    for (int t = 4; t >= 1; t--) begin
      writeback(t, 32'(100 + t), 1'b0, 1'b0, '0);
      chk("R4 no commit before head done", 64'(cm_valid), 64'd0);
    end
    writeback(0, 32'd100, 1'b0, 1'b0, '0);
    repeat (7) step();
    chk("R5 commit count", 64'(ncm), 64'd5);
    for (int i = 0; i < 5; i++) begin
      chk("R5 commit dst order", 64'(log_dst[i]), 64'(i + 1));
      chk("R5 commit value", 64'(log_val[i]), 64'(100 + i));
    end

    // R2 R3: fill from tail 5 so the tags wrap
    for (int i = 0; i < DEPTH; i++) dispatch(RW'(i + 1), 32'h300, (5 + i) % DEPTH);
    #1;
    chk("R3 disp_ready when full", 64'(disp_ready), 64'd0);
    disp_valid = 1'b1; disp_dst = 5'd31; disp_pc = 32'h999;
    step();
    disp_valid = 1'b0;
    #1;
    chk("R3 tail held when full", 64'(disp_tag), 64'd5);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) writeback((5 + i) % DEPTH, 32'(200 + i), 1'b0, 1'b0, '0);
    repeat (10) step();
    chk("R3 exactly eight commits", 64'(ncm), 64'd13);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 commit dst", 64'(log_dst[5 + i]), 64'(i + 1));
      chk("R5 commit value wrap", 64'(log_val[5 + i]), 64'(200 + i));
    end
    chk("R3 empty after drain", 64'(disp_ready), 64'd1);

    // R8 R9: duplicate destinations; tags 5,6,7
    dispatch(5'd7, 32'h400, 5);
    dispatch(5'd9, 32'h404, 6);
    dispatch(5'd7, 32'h408, 7);
    lookup("R8 youngest pending", 5'd7, 32'h0, 1'b1, 1'b0, 32'h0, 7);
    writeback(5, 32'h55, 1'b0, 1'b0, '0);
    lookup("R8 older done younger pending", 5'd7, 32'h0, 1'b1, 1'b0, 32'h0, 7);
    writeback(7, 32'h77, 1'b0, 1'b0, '0);
    lookup("R8 youngest done", 5'd7, 32'h0, 1'b1, 1'b1, 32'h77, 7);
    lookup("R8 other pending", 5'd9, 32'h0, 1'b1, 1'b0, 32'h0, 6);
    lookup("R9 miss uses arf", 5'd12, 32'hABC, 1'b0, 1'b1, 32'hABC, 0);
    @(negedge clk);
    writeback(6, 32'h66, 1'b0, 1'b0, '0);
    repeat (5) step();
    chk("R5 commit count after lookups", 64'(ncm), 64'd16);
    lookup("R9 committed reg uses arf", 5'd7, 32'h1234, 1'b0, 1'b1, 32'h1234, 0);
    @(negedge clk);

    // R6: fault at head, younger slots completed first
    dispatch(5'd3, 32'h200, 0);
    dispatch(5'd4, 32'h204, 1);
    dispatch(5'd5, 32'h208, 2);
    writeback(1, 32'h1, 1'b0, 1'b0, '0);
    writeback(2, 32'h2, 1'b0, 1'b0, '0);
    writeback(0, 32'h0, 1'b1, 1'b0, '0);
    #1;
    chk("R6 flush_valid", 64'(flush_valid), 64'd1);
    chk("R6 flush_fault", 64'(flush_fault), 64'd1);
    chk("R6 flush_pc handler", 64'(flush_pc), 64'(HANDLER));
    chk("R6 flush_epc", 64'(flush_epc), 64'h200);
    chk("R6 no register write", 64'(cm_valid), 64'd0);
    step();
    #1;
    chk("R6 tail reset", 64'(disp_tag), 64'd0);
    chk("R6 flush done", 64'(flush_valid), 64'd0);
    @(negedge clk);
    repeat (4) step();
    chk("R6 younger never commit", 64'(ncm), 64'd16);
    lookup("R6 slots discarded", 5'd4, 32'h44, 1'b0, 1'b1, 32'h44, 0);
    @(negedge clk);

    // R7 R10: mispredicted branch at head, dispatch attempted during flush
    dispatch(5'd10, 32'h500, 0);
    dispatch(5'd11, 32'h504, 1);
    dispatch(5'd12, 32'h508, 2);
    writeback(1, 32'h11, 1'b0, 1'b0, '0);
    writeback(2, 32'h12, 1'b0, 1'b0, '0);
    writeback(0, 32'h99, 1'b0, 1'b1, 32'h4000);
    disp_valid = 1'b1; disp_dst = 5'd20; disp_pc = 32'h600;
    #1;
    chk("R7 branch commits", 64'(cm_valid), 64'd1);
    chk("R7 branch dst", 64'(cm_dst), 64'd10);
    chk("R7 branch value", 64'(cm_value), 64'h99);
    chk("R7 flush_valid", 64'(flush_valid), 64'd1);
    chk("R7 flush_fault", 64'(flush_fault), 64'd0);
    chk("R7 flush_pc target", 64'(flush_pc), 64'h4000);
    step();
    disp_valid = 1'b0;
    #1;
    chk("R10 no slot from flush-cycle dispatch", 64'(disp_tag), 64'd0);
    lookup("R10 flush-cycle dispatch absent", 5'd20, 32'h2020, 1'b0, 1'b1, 32'h2020, 0);
    lookup("R7 younger discarded", 5'd11, 32'h1111, 1'b0, 1'b1, 32'h1111, 0);
    @(negedge clk);
    repeat (4) step();
    chk("R7 only the branch commits", 64'(ncm), 64'd17);
    chk("R7 logged branch dst", 64'(log_dst[16]), 64'd10);

    summary();
    $finish;
  end

endmodule